// File: doc/BRIEF.md
# Modem Handshake Control with Diagnostic Loopback

This block turns a small control word into the active-low handshake pins of a serial port. It also gates the port's interrupt line, and it provides a self-test loopback. The control word is captured on each clock edge. In normal operation two of its bits drive the data-terminal-ready and request-to-send pins. A third bit is a spare flag with no pin, and a fourth enables the interrupt output. The four incoming handshake pins (clear-to-send, data-set-ready, ring indicator, carrier detect) pass through a short synchronizer and are inverted into active-high status bits.

When the loopback bit is set, the block cuts the serial path and the handshake lines off from the outside world. The transmit pin idles at mark. The transmitter's serial output is fed straight to the receiver input. The outgoing handshake pins rest at their inactive high level. The status bits are then taken from the control bits: DTR feeds DSR, RTS feeds CTS, the spare flag feeds RI, and the interrupt-enable bit feeds DCD. Firmware can therefore test the transmit, receive and modem-status paths without a cable. The interrupt gate keeps working in loopback.

Top module: `mdm_loopback_ctl`

## Requirements
- R1: In normal mode (control bit 4 clear), control bit 0 set drives `dtr_n` low, and bit 0 clear drives it high.
- R2: In normal mode, control bit 1 drives `rts_n` with the same inverted sense as R1.
- R3: Control bit 2 changes no output pin in normal mode. It is visible only as the RI status bit (`stat[2]`) in loopback.
- R4: `irq_oe` equals control bit 3 and `irq_out` equals `irq_req` AND control bit 3, in both normal and loopback mode.
- R5: With control bit 4 set, `tx_pin` is 1. Otherwise `tx_pin` follows `tx_ser` within the same cycle.
- R6: With control bit 4 set, `rx_core` follows `tx_ser` within the same cycle and `rx_pin` is ignored. Otherwise `rx_core` follows `rx_pin`.
- R7: In loopback the status bits are `stat[0]`=CTS=bit 1, `stat[1]`=DSR=bit 0, `stat[2]`=RI=bit 2 and `stat[3]`=DCD=bit 3, and all four external modem inputs are ignored.
- R8: In loopback, `dtr_n` and `rts_n` are both high regardless of bits 0 and 1.
- R9: In normal mode each status bit (`stat[0]` CTS, `stat[1]` DSR, `stat[2]` RI, `stat[3]` DCD) is the inverse of its pin, delayed by exactly SYNC_STAGES clock edges. The status bits read 0 during reset.
- R10: A new control word takes effect at the first rising clock edge after it is applied, and not before. During reset the control word reads as zero: `dtr_n`=1, `rts_n`=1, `irq_oe`=0, `irq_out`=0, and `tx_pin` follows `tx_ser`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_in | input | 5 | Control word: bit0 DTR, bit1 RTS, bit2 spare flag, bit3 interrupt enable, bit4 loopback |
| tx_ser | input | 1 | Serial output of the transmitter shifter |
| rx_pin | input | 1 | External receive pin |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| ri_n | input | 1 | Ring indicator pin, active low |
| dcd_n | input | 1 | Carrier detect pin, active low |
| irq_req | input | 1 | Interrupt request from the port's interrupt logic |
| tx_pin | output | 1 | External transmit pin |
| rx_core | output | 1 | Serial input presented to the receiver shifter |
| dtr_n | output | 1 | Data-terminal-ready pin, active low |
| rts_n | output | 1 | Request-to-send pin, active low |
| stat | output | 4 | Active-high status: [0] CTS, [1] DSR, [2] RI, [3] DCD |
| irq_out | output | 1 | Gated interrupt output |
| irq_oe | output | 1 | Interrupt pin drive enable; 0 means the line floats |

## Verification
A corrupted captured control word shows up on the handshake pins, the interrupt enable or the mark level one edge after the word is applied. The bench sweeps every control word against every combination of pin, serial and interrupt levels, so any stuck or swapped bit gives a miscompare within two cycles. A fault in the loopback crosswiring or the serial multiplexers appears on `stat`, `rx_core` or `tx_pin` without any clock edge being needed. A synchronizer with the wrong depth or the wrong reset value changes when a pin edge reaches `stat`, and the bench checks that edge-by-edge timing explicitly.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
   localparam int CTRL_W   = 5;
   localparam int MDM_W    = 4;
   localparam int BIT_DTR  = 0;
   localparam int BIT_RTS  = 1;
   localparam int BIT_OUT1 = 2;
   localparam int BIT_OUT2 = 3;
   localparam int BIT_LOOP = 4;

   // Active-high modem status, CTS in the low bit.
   typedef struct packed {
      logic dcd;
      logic ri;
      logic dsr;
      logic cts;
   } mdm_stat_t;
endpackage

// File: rtl/mdm_ctrl_reg.sv
module mdm_ctrl_reg
   import mdm_pkg::*;
#(
   parameter int WIDTH = CTRL_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (WIDTH < CTRL_W) begin : g_width_bad
      $error("mdm_ctrl_reg: WIDTH must cover all control bits");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
   end
endmodule

// File: rtl/mdm_in_sync.sv
module mdm_in_sync #(
   parameter int           WIDTH  = 4,
   parameter int           STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   localparam int LAST = (STAGES > 0) ? STAGES - 1 : 0;

   if (STAGES < 0 || STAGES > 4) begin : g_depth_bad
      $error("mdm_in_sync: STAGES must be 0..4");
   end

   if (STAGES == 0) begin : g_thru
      assign q = d;
   end else begin : g_chain
      logic [WIDTH-1:0] stg [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[0] <= RST_VAL;
         else        stg[0] <= d;
      end
      for (genvar i = 1; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= RST_VAL;
            else        stg[i] <= stg[i-1];
         end
      end
      assign q = stg[LAST];
   end
endmodule

// File: rtl/mdm_path_mux.sv
module mdm_path_mux
   import mdm_pkg::*;
(
   input  logic [CTRL_W-1:0] ctrl_q,
   input  logic [MDM_W-1:0]  pin_s_n,
   input  logic              tx_ser,
   input  logic              rx_pin,
   input  logic              irq_req,
   output logic              tx_pin,
   output logic              rx_core,
   output logic              dtr_n,
   output logic              rts_n,
   output mdm_stat_t         stat,
   output logic              irq_out,
   output logic              irq_oe
);
   logic      loop;
   mdm_stat_t stat_ext;
   mdm_stat_t stat_loop;

   assign loop = ctrl_q[BIT_LOOP];

   // Serial path: the pin idles at mark while the shifter output is looped back.
   assign tx_pin  = loop ? 1'b1   : tx_ser;
   assign rx_core = loop ? tx_ser : rx_pin;

   // Handshake outputs rest at their inactive level in loopback.
   assign dtr_n = loop | ~ctrl_q[BIT_DTR];
   assign rts_n = loop | ~ctrl_q[BIT_RTS];

   assign stat_ext = mdm_stat_t'(~pin_s_n);

   always_comb begin
      stat_loop     = '0;
      stat_loop.cts = ctrl_q[BIT_RTS];
      stat_loop.dsr = ctrl_q[BIT_DTR];
      stat_loop.ri  = ctrl_q[BIT_OUT1];
      stat_loop.dcd = ctrl_q[BIT_OUT2];
   end

   assign stat = loop ? stat_loop : stat_ext;

   assign irq_oe  = ctrl_q[BIT_OUT2];
   assign irq_out = irq_req & ctrl_q[BIT_OUT2];
endmodule

// File: rtl/mdm_loopback_ctl.sv
module mdm_loopback_ctl
   import mdm_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CTRL_W-1:0] ctrl_in,
   input  logic              tx_ser,
   input  logic              rx_pin,
   input  logic              cts_n,
   input  logic              dsr_n,
   input  logic              ri_n,
   input  logic              dcd_n,
   input  logic              irq_req,
   output logic              tx_pin,
   output logic              rx_core,
   output logic              dtr_n,
   output logic              rts_n,
   output logic [MDM_W-1:0]  stat,
   output logic              irq_out,
   output logic              irq_oe
);
   logic [CTRL_W-1:0] ctrl_q;
   logic [MDM_W-1:0]  pin_n;
   logic [MDM_W-1:0]  pin_s_n;
   mdm_stat_t         stat_s;

   assign pin_n = {dcd_n, ri_n, dsr_n, cts_n};

   mdm_ctrl_reg #(.WIDTH(CTRL_W)) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ctrl_in),
      .q     (ctrl_q)
   );

   mdm_in_sync #(.WIDTH(MDM_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_n),
      .q     (pin_s_n)
   );

   mdm_path_mux u_mux (
      .ctrl_q  (ctrl_q),
      .pin_s_n (pin_s_n),
      .tx_ser  (tx_ser),
      .rx_pin  (rx_pin),
      .irq_req (irq_req),
      .tx_pin  (tx_pin),
      .rx_core (rx_core),
      .dtr_n   (dtr_n),
      .rts_n   (rts_n),
      .stat    (stat_s),
      .irq_out (irq_out),
      .irq_oe  (irq_oe)
   );

   assign stat = stat_s;

   assert_dtr_drive_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_in[BIT_LOOP] |=> dtr_n == !$past(ctrl_in[BIT_DTR]));

   assert_rts_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_in[BIT_LOOP] |=> rts_n == !$past(ctrl_in[BIT_RTS]));

   assert_irq_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_in[BIT_OUT2] |=> !irq_oe && !irq_out);

   assert_tx_mark_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_in[BIT_LOOP] |=> tx_pin);

   assert_rx_loop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_in[BIT_LOOP] |=> rx_core == tx_ser);

   assert_stat_cross_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_in[BIT_LOOP] |=> stat == {$past(ctrl_in[BIT_OUT2]), $past(ctrl_in[BIT_OUT1]),
                                     $past(ctrl_in[BIT_DTR]), $past(ctrl_in[BIT_RTS])});

   assert_pins_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_in[BIT_LOOP] |=> dtr_n && rts_n);
endmodule

// File: tb/mdm_loopback_ctl_tb.sv
module mdm_loopback_ctl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int SYNC       = 2;
   localparam int SETTLE     = (SYNC > 1) ? SYNC : 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] ctrl_in = '0;
   logic       tx_ser = 1'b0, rx_pin = 1'b1;
   logic       cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
   logic       irq_req = 1'b0;
   logic       tx_pin, rx_core, dtr_n, rts_n, irq_out, irq_oe;
   logic [3:0] stat;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mdm_loopback_ctl #(.SYNC_STAGES(SYNC)) u_dut (
      .clk(clk), .rst_n(rst_n), .ctrl_in(ctrl_in), .tx_ser(tx_ser), .rx_pin(rx_pin),
      .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .dcd_n(dcd_n), .irq_req(irq_req),
      .tx_pin(tx_pin), .rx_core(rx_core), .dtr_n(dtr_n), .rts_n(rts_n),
      .stat(stat), .irq_out(irq_out), .irq_oe(irq_oe)
   );

   task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h (ctrl=%b t=%0t)", tag, act, exp, ctrl_in, $time);
      end
   endtask

   // Compare every output against the value computed from the requirements.
   task automatic check_all(input logic [4:0] c, input string tag);
      logic       lp;
      logic [3:0] es;
      lp = c[4];
      es = lp ? {c[3], c[2], c[0], c[1]} : ~{dcd_n, ri_n, dsr_n, cts_n};
      chk({tag, " R5 tx_pin"},  {3'b0, tx_pin},  {3'b0, lp ? 1'b1 : tx_ser});
      chk({tag, " R6 rx_core"}, {3'b0, rx_core}, {3'b0, lp ? tx_ser : rx_pin});
      chk({tag, " R1 R8 dtr_n"}, {3'b0, dtr_n},  {3'b0, lp | ~c[0]});
      chk({tag, " R2 R8 rts_n"}, {3'b0, rts_n},  {3'b0, lp | ~c[1]});
      chk({tag, " R3 R7 R9 stat"}, stat, es);
      chk({tag, " R4 irq_oe"},  {3'b0, irq_oe},  {3'b0, c[3]});
      chk({tag, " R4 irq_out"}, {3'b0, irq_out}, {3'b0, irq_req & c[3]});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      // R10 reset state with a non-zero control word already applied
      ctrl_in = 5'h1F;
      irq_req = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      check_all(5'h00, "reset R10");

      // R10 latency: entering loopback takes effect at the first edge only
      @(negedge clk);
      rst_n   = 1'b1;
      ctrl_in = 5'h13;
      #1;
      check_all(5'h00, "pre-edge R10");
      @(posedge clk); #1;
      check_all(5'h13, "post-edge R10");
      @(negedge clk);
      ctrl_in = 5'h03;
      #1;
      check_all(5'h13, "pre-edge leave R10");
      @(posedge clk); #1;
      check_all(5'h03, "post-edge leave R10");

      // R6 same-cycle serial loopback without a clock edge
      @(negedge clk);
      ctrl_in = 5'h10;
      @(posedge clk); #1;
      tx_ser = 1'b1; rx_pin = 1'b0; #1;
      chk("R6 loop follow hi", {3'b0, rx_core}, 4'h1);
      tx_ser = 1'b0; #1;
      chk("R6 loop follow lo", {3'b0, rx_core}, 4'h0);
      chk("R5 loop mark", {3'b0, tx_pin}, 4'h1);

      // R9 synchronizer depth: pin edge reaches stat after exactly SYNC edges
      @(negedge clk);
      ctrl_in = 5'h00;
      repeat (SYNC + 1) @(posedge clk);
      @(negedge clk);
      cts_n = 1'b0; dcd_n = 1'b0;
      for (int e = 1; e <= SYNC; e++) begin
         @(posedge clk); #1;
         chk("R9 sync timing", stat, (e < SYNC) ? 4'h0 : 4'h9);
      end

      // Sweep every control word against every pin/serial/irq combination
      for (int v = 0; v < 4096; v++) begin
         @(negedge clk);
         ctrl_in = v[4:0];
         cts_n   = v[5];
         dsr_n   = v[6];
         ri_n    = v[7];
         dcd_n   = v[8];
         tx_ser  = v[9];
         rx_pin  = v[10];
         irq_req = v[11];
         repeat (SETTLE) @(posedge clk);
         #1;
         check_all(v[4:0], "sweep");
      end

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule